// File: doc/BRIEF.md
# Guarded Watchdog Timer

The block counts ticks of a slow, separately generated time base and raises a reset pulse one clock wide when a chosen number of ticks passes without a service strobe. A 3-bit period field selects a timeout of 2^(MIN_EXP+p) ticks, where p is the field value. With the default `MIN_EXP` of 14 this covers 2^14 through 2^21 ticks. The service strobe (`kick_i`) clears the tick count to zero.

The enable bit and the period field sit behind a timed unlock. A write with both the change bit and the enable bit at one opens a window. This holds even when the watchdog is already running. The window lasts `WIN` clocks, 4 by default. The next write inside the window sets the enable and period together and closes the window. If no write arrives, the window closes by itself. Two static inputs pick one of three protection levels. `lvl_lock_i` selects the strict level, where the watchdog cannot be turned off. Otherwise `lvl_relax_i` selects the lenient level, and with both low the middle level applies.

Two state machines form the block. The unlock machine has the state `WIN_SHUT`, which moves to `WIN_OPEN` on an unlock write. It returns from `WIN_OPEN` to `WIN_SHUT` on any write, or when the window count reaches `WIN-1`. The pulse machine has the state `PULSE_IDLE`, which moves to `PULSE_FIRE` on expiry. `PULSE_FIRE` always returns to `PULSE_IDLE` after one cycle.

Top module: `wdog_guard`

## Requirements
- R1: After reset `per_o` is 0, `win_o` is 0 and `wdt_rst_o` is 0. `en_o` is 0 at levels 0 and 1 and is 1 at level 2.
- R2: While enabled, `wdt_rst_o` rises right after the 2^(MIN_EXP+p)-th tick counted since enable, service or the last pulse, where p is `per_o`. It is high for exactly one cycle, and counting then restarts from zero.
- R3: `kick_i` clears the tick count. A service strobe in the same cycle as the final tick suppresses the pulse, and a full period follows it.
- R4: While `en_o` is 0, ticks have no effect and `wdt_rst_o` stays 0.
- R5: A write with `wr_chg_i`=1 and `wr_en_i`=1 opens the window, even when the watchdog is already enabled. `win_o` is then 1 for exactly `WIN` cycles unless a write closes it first.
- R6: A write made while `win_o` is 1 loads `wr_en_i` and `wr_per_i` into the enable and period, and `win_o` drops in the next cycle.
- R7: A write arriving one cycle after the window has timed out is handled as a plain write and cannot disable the watchdog.
- R8: At level 0, a plain write loads the period freely and can set the enable, but clearing the enable requires the window.
- R9: At level 1, a plain write can set the enable. Clearing the enable or changing the period requires the window.
- R10: At level 2, `en_o` is always 1. A plain write changes nothing. A window write loads only the period, and its enable value is overridden to 1.
- R11: Level selection works as follows. `lvl_lock_i`=1 gives level 2 whatever `lvl_relax_i` is. Otherwise `lvl_relax_i`=1 gives level 0, and both at 0 gives level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_relax_i | input | 1 | Static: selects level 0 when `lvl_lock_i` is low |
| lvl_lock_i | input | 1 | Static: selects level 2 |
| wr_i | input | 1 | Control write strobe |
| wr_chg_i | input | 1 | Change bit of the write |
| wr_en_i | input | 1 | Enable bit of the write |
| wr_per_i | input | PER_W | Period field of the write |
| kick_i | input | 1 | Service strobe; clears the tick count |
| tick_i | input | 1 | One-cycle tick from the slow time base |
| wdt_rst_o | output | 1 | One-cycle reset pulse on expiry |
| en_o | output | 1 | Effective enable |
| per_o | output | PER_W | Current period field |
| win_o | output | 1 | Unlock window open |

## Verification
The bench builds the block with `MIN_EXP`=2 and `PER_W`=3, so a period field p means 2^(2+p) ticks. Every period setting therefore expires within a few hundred ticks, including 64 ticks at p=4. This makes the exact pulse position, the restart after a pulse and the same-cycle service corner reachable in a short run. `WIN` stays at 4, so the bench probes the window edge directly. A write 3 idle cycles after the unlock is accepted, and a write 4 idle cycles after it is refused. Each level is entered through a reset with the static inputs changed.

// File: rtl/wdog_guard_pkg.sv
package wdog_guard_pkg;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2
    } safe_lvl_e;

    typedef enum logic {
        WIN_SHUT = 1'b0,
        WIN_OPEN = 1'b1
    } win_st_e;

    typedef enum logic {
        PULSE_IDLE = 1'b0,
        PULSE_FIRE = 1'b1
    } fire_st_e;

    // lock input dominates; relax picks the lenient level
    function automatic safe_lvl_e lvl_decode(input logic relax, input logic lock);
        if (lock) begin
            return LVL2;
        end else if (relax) begin
            return LVL0;
        end
        return LVL1;
    endfunction

endpackage

// File: rtl/wdog_cfg_guard.sv
module wdog_cfg_guard
    import wdog_guard_pkg::*;
#(
    parameter int PER_W = 3,
    parameter int WIN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_relax_i,
    input  logic             lvl_lock_i,
    input  logic             wr_i,
    input  logic             wr_chg_i,
    input  logic             wr_en_i,
    input  logic [PER_W-1:0] wr_per_i,
    output logic             en_o,
    output logic [PER_W-1:0] per_o,
    output logic             win_o
);

    localparam int WC_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN - 1);

    safe_lvl_e        lvl;
    win_st_e          st_q, st_n;
    logic [WC_W-1:0]  wc_q, wc_n;
    logic             en_q, en_n;
    logic [PER_W-1:0] per_q, per_n;
    logic             unlock_req;

    assign lvl        = lvl_decode(lvl_relax_i, lvl_lock_i);
    assign unlock_req = wr_i && wr_chg_i && wr_en_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WIN_SHUT;
            wc_q  <= '0;
            en_q  <= 1'b0;
            per_q <= '0;
        end else begin
            st_q  <= st_n;
            wc_q  <= wc_n;
            en_q  <= en_n;
            per_q <= per_n;
        end
    end

    // transitions and field updates
    always_comb begin
        st_n  = st_q;
        wc_n  = wc_q;
        en_n  = en_q;
        per_n = per_q;
        unique case (st_q)
            WIN_SHUT: begin
                if (wr_i) begin
                    unique case (lvl)
                        LVL0: begin
                            en_n  = en_q | wr_en_i;
                            per_n = wr_per_i;
                        end
                        LVL1: begin
                            en_n  = en_q | wr_en_i;
                        end
                        default: begin
                            en_n  = en_q;
                        end
                    endcase
                end
                if (unlock_req) begin
                    st_n = WIN_OPEN;
                    wc_n = '0;
                end
            end
            WIN_OPEN: begin
                if (wr_i) begin
                    en_n  = wr_en_i;
                    per_n = wr_per_i;
                    st_n  = WIN_SHUT;
                    wc_n  = '0;
                end else if (wc_q == WC_LAST) begin
                    st_n  = WIN_SHUT;
                    wc_n  = '0;
                end else begin
                    wc_n  = wc_q + 1'b1;
                end
            end
            default: begin
                st_n = WIN_SHUT;
            end
        endcase
    end

    // outputs
    always_comb begin
        en_o  = en_q || (lvl == LVL2);
        per_o = per_q;
        win_o = (st_q == WIN_OPEN);
    end

endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
    parameter int MIN_EXP = 14,
    parameter int PER_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PER_W-1:0] per_i,
    input  logic             kick_i,
    input  logic             tick_i,
    output logic             expire_o
);

    localparam int MAX_EXP = MIN_EXP + (2 ** PER_W) - 1;
    localparam int CNT_W   = MAX_EXP;
    localparam int SH_W    = $clog2(MAX_EXP + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  sh;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;
    logic             at_end;

    assign sh     = SH_W'(MIN_EXP) + SH_W'(per_i);
    assign span   = {{CNT_W{1'b0}}, 1'b1} << sh;
    assign last   = span[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
    assign at_end = (cnt_q >= last);

    assign expire_o = en_i && tick_i && !kick_i && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || kick_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_fire.sv
module wdog_fire
    import wdog_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    output logic pulse_o
);

    fire_st_e st_q, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PULSE_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            PULSE_IDLE: st_n = expire_i ? PULSE_FIRE : PULSE_IDLE;
            PULSE_FIRE: st_n = PULSE_IDLE;
            default:    st_n = PULSE_IDLE;
        endcase
        pulse_o = (st_q == PULSE_FIRE);
    end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
    parameter int MIN_EXP = 14,
    parameter int PER_W   = 3,
    parameter int WIN     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_relax_i,
    input  logic             lvl_lock_i,
    input  logic             wr_i,
    input  logic             wr_chg_i,
    input  logic             wr_en_i,
    input  logic [PER_W-1:0] wr_per_i,
    input  logic             kick_i,
    input  logic             tick_i,
    output logic             wdt_rst_o,
    output logic             en_o,
    output logic [PER_W-1:0] per_o,
    output logic             win_o
);

    logic             en_w;
    logic [PER_W-1:0] per_w;
    logic             expire_w;

    wdog_cfg_guard #(
        .PER_W (PER_W),
        .WIN   (WIN)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_relax_i (lvl_relax_i),
        .lvl_lock_i  (lvl_lock_i),
        .wr_i        (wr_i),
        .wr_chg_i    (wr_chg_i),
        .wr_en_i     (wr_en_i),
        .wr_per_i    (wr_per_i),
        .en_o        (en_w),
        .per_o       (per_w),
        .win_o       (win_o)
    );

    wdog_presc #(
        .MIN_EXP (MIN_EXP),
        .PER_W   (PER_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_w),
        .per_i    (per_w),
        .kick_i   (kick_i),
        .tick_i   (tick_i),
        .expire_o (expire_w)
    );

    wdog_fire u_fire (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire_w),
        .pulse_o  (wdt_rst_o)
    );

    assign en_o  = en_w;
    assign per_o = per_w;

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int PER_W = 3,
    parameter int WIN   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lvl_relax_i,
    input logic             lvl_lock_i,
    input logic             wdt_rst_o,
    input logic             en_o,
    input logic [PER_W-1:0] per_o,
    input logic             win_o
);

    localparam int LEN_W = $clog2(WIN + 2);

    logic [LEN_W-1:0] open_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_len <= '0;
        end else if (win_o) begin
            open_len <= open_len + 1'b1;
        end else begin
            open_len <= '0;
        end
    end

    // R2
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);

    // R4
    off_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> !wdt_rst_o);

    // R5
    win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_len <= LEN_W'(WIN));

    // R9
    disable_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_o) |-> $past(win_o));

    // R9
    per_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_relax_i && !$stable(per_o)) |-> $past(win_o));

    // R10
    lock_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_lock_i |-> en_o);

endmodule

bind wdog_guard wdog_guard_chk #(
    .PER_W (PER_W),
    .WIN   (WIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_relax_i (lvl_relax_i),
    .lvl_lock_i  (lvl_lock_i),
    .wdt_rst_o   (wdt_rst_o),
    .en_o        (en_o),
    .per_o       (per_o),
    .win_o       (win_o)
);

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;

    localparam int MIN_EXP = 2;
    localparam int PER_W   = 3;
    localparam int WIN     = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lvl_relax_i = 1'b0;
    logic             lvl_lock_i = 1'b0;
    logic             wr_i = 1'b0;
    logic             wr_chg_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [PER_W-1:0] wr_per_i = '0;
    logic             kick_i = 1'b0;
    logic             tick_i = 1'b0;
    logic             wdt_rst_o;
    logic             en_o;
    logic [PER_W-1:0] per_o;
    logic             win_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_guard #(
        .MIN_EXP (MIN_EXP),
        .PER_W   (PER_W),
        .WIN     (WIN)
    ) u_wdog_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_relax_i (lvl_relax_i),
        .lvl_lock_i  (lvl_lock_i),
        .wr_i        (wr_i),
        .wr_chg_i    (wr_chg_i),
        .wr_en_i     (wr_en_i),
        .wr_per_i    (wr_per_i),
        .kick_i      (kick_i),
        .tick_i      (tick_i),
        .wdt_rst_o   (wdt_rst_o),
        .en_o        (en_o),
        .per_o       (per_o),
        .win_o       (win_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic relax, input logic lock);
        @(negedge clk);
        rst_n       = 1'b0;
        lvl_relax_i = relax;
        lvl_lock_i  = lock;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic chg, input logic en, input logic [PER_W-1:0] per);
        wr_i = 1'b1; wr_chg_i = chg; wr_en_i = en; wr_per_i = per;
        @(negedge clk);
        wr_i = 1'b0; wr_chg_i = 1'b0; wr_en_i = 1'b0; wr_per_i = '0;
    endtask

    task automatic give_tick(input logic with_kick);
        tick_i = 1'b1; kick_i = with_kick;
        @(negedge clk);
        tick_i = 1'b0; kick_i = 1'b0;
    endtask

    task automatic do_kick();
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
    endtask

    // feed n-1 ticks expecting no pulse, then the n-th expecting one
    task automatic expect_expiry(input string req, input int n);
        int early = 0;
        for (int i = 0; i < n - 1; i++) begin
            give_tick(1'b0);
            if (wdt_rst_o) early++;
        end
        check({req, " no early pulse"}, early, 0);
        give_tick(1'b0);
        check({req, " pulse at final tick"}, int'(wdt_rst_o), 1);
        idle(1);
        check({req, " pulse one cycle"}, int'(wdt_rst_o), 0);
    endtask

    task automatic t_reset();
        restart(1'b0, 1'b0);
        check("R1 en", int'(en_o), 0);
        check("R1 per", int'(per_o), 0);
        check("R1 win", int'(win_o), 0);
        check("R1 pulse", int'(wdt_rst_o), 0);
        restart(1'b0, 1'b1);
        check("R1 level2 en", int'(en_o), 1);
    endtask

    task automatic t_disabled();
        int seen = 0;
        restart(1'b0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            give_tick(1'b0);
            if (wdt_rst_o) seen++;
        end
        check("R4 no pulse while off", seen, 0);
    endtask

    task automatic t_timeout();
        restart(1'b0, 1'b0);
        do_write(1'b0, 1'b1, 3'd0);
        check("R9 enable free", int'(en_o), 1);
        expect_expiry("R2 p0", 4);
        expect_expiry("R2 restart", 4);
        do_write(1'b1, 1'b1, 3'd0);
        do_write(1'b0, 1'b1, 3'd1);
        check("R6 period load", int'(per_o), 1);
        do_kick();
        expect_expiry("R2 p1", 8);
    endtask

    task automatic t_kick();
        int seen = 0;
        restart(1'b0, 1'b0);
        do_write(1'b0, 1'b1, 3'd0);
        for (int i = 0; i < 3; i++) give_tick(1'b0);
        do_kick();
        expect_expiry("R3 after kick", 4);
        for (int i = 0; i < 3; i++) give_tick(1'b0);
        give_tick(1'b1);
        if (wdt_rst_o) seen++;
        idle(1);
        if (wdt_rst_o) seen++;
        check("R3 kick on final tick", seen, 0);
        expect_expiry("R3 full period after", 4);
    endtask

    task automatic t_window();
        int hi = 0;
        restart(1'b0, 1'b0);
        do_write(1'b0, 1'b1, 3'd0);
        do_write(1'b1, 1'b1, 3'd0);
        for (int i = 0; i < WIN; i++) begin
            if (win_o) hi++;
            idle(1);
        end
        check("R5 window length", hi, WIN);
        check("R5 window closed", int'(win_o), 0);
        do_write(1'b1, 1'b1, 3'd0);
        idle(3);
        do_write(1'b0, 1'b0, 3'd5);
        check("R6 disable in window", int'(en_o), 0);
        check("R6 period in window", int'(per_o), 5);
        check("R6 window shut", int'(win_o), 0);
        do_write(1'b0, 1'b1, 3'd5);
        do_write(1'b1, 1'b1, 3'd5);
        idle(4);
        do_write(1'b0, 1'b0, 3'd2);
        check("R7 late en", int'(en_o), 1);
        check("R7 late per", int'(per_o), 5);
        do_write(1'b0, 1'b0, 3'd3);
        check("R9 plain disable", int'(en_o), 1);
        check("R9 plain period", int'(per_o), 5);
    endtask

    task automatic t_level0();
        restart(1'b1, 1'b0);
        check("R11 relax only off", int'(en_o), 0);
        do_write(1'b0, 1'b1, 3'd6);
        check("R8 enable", int'(en_o), 1);
        check("R8 period", int'(per_o), 6);
        do_write(1'b0, 1'b0, 3'd1);
        check("R8 plain disable", int'(en_o), 1);
        check("R8 free period", int'(per_o), 1);
        do_write(1'b1, 1'b1, 3'd1);
        do_write(1'b0, 1'b0, 3'd1);
        check("R8 window disable", int'(en_o), 0);
    endtask

    task automatic t_level2();
        restart(1'b1, 1'b1);
        check("R11 lock wins", int'(en_o), 1);
        do_write(1'b0, 1'b0, 3'd4);
        check("R10 plain period", int'(per_o), 0);
        check("R10 plain en", int'(en_o), 1);
        do_write(1'b1, 1'b1, 3'd0);
        do_write(1'b0, 1'b0, 3'd4);
        check("R10 window period", int'(per_o), 4);
        check("R10 stays on", int'(en_o), 1);
        do_kick();
        expect_expiry("R10 timeout p4", 64);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_disabled();
        t_timeout();
        t_kick();
        t_window();
        t_level0();
        t_level2();
        finish_run();
    end

endmodule